// File: doc/BRIEF.md
# Stack Pop Pointer Update Unit

This unit carries out the stack-pointer half of a pop micro-operation in a small processor datapath. A one-cycle start pulse hands it the current pointer and three pieces of context. The first is the stack width (16 or 32 bits). The second is the operand width (16 or 32 bits). The third is a destination code: an ordinary target, the stack pointer itself, or a memory operand that uses the stack pointer as its base register. The unit then raises a read request at the old top of stack and asks for 2 or 4 bytes.

When the memory side returns a one-cycle acknowledge with the data, the unit commits the new pointer. The size of the step follows the operand width. How much of the register takes part follows the stack width. A memory destination based on the stack pointer gets an effective-address base taken from the already-stepped pointer. A pop into the stack pointer itself ends with the popped value in the pointer.

Top module: `stkpop_unit`

## Requirements
- R1: While reset is held and in the cycle after it, busy_o, rd_req_o, sp_wr_o and ea_base_vld_o are 0, rd_addr_o, sp_next_o and ea_base_o are 0, and rd_bytes_o is 2.
- R2: A start_i sampled high while busy_o is low raises busy_o and rd_req_o in the next cycle. rd_addr_o then equals the old pointer: the full 32 bits on a 32-bit stack (stk_wide_i=1), or the low 16 bits zero-extended on a 16-bit stack (stk_wide_i=0).
- R3: rd_bytes_o is 4 when op_wide_i was 1 at start, and 2 when it was 0. The stack width has no effect on it.
- R4: On a 32-bit stack, the committed pointer is the old pointer plus rd_bytes_o, modulo 2^32.
- R5: On a 16-bit stack, the low 16 bits of the committed pointer are the old low half plus rd_bytes_o, modulo 2^16, and the upper 16 bits keep their old value.
- R6: An rd_ack_i sampled high while rd_req_o is high drops rd_req_o and busy_o in the next cycle. In that same cycle sp_wr_o is high for exactly one cycle, with sp_next_o valid. A new start may be accepted during that cycle.
- R7: On every commit, ea_base_o carries the address view of the stepped pointer, formed as in R2. ea_base_vld_o is high with sp_wr_o only when the destination code (dst_i) was 2, meaning memory based on the stack pointer.
- R8: For destination code 1 (the stack pointer itself), the committed pointer is rd_data_i when op_wide_i=1. When op_wide_i=0, it is the stepped pointer with its low 16 bits replaced by rd_data_i[15:0]. Codes 0 and 3 commit the stepped pointer.
- R9: A start_i pulse while busy_o is high has no effect: the address, the byte count and the committed result of the pending pop are unchanged.
- R10: While rd_req_o is high and no acknowledge arrives, rd_req_o, rd_addr_o and rd_bytes_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a pop (accepted when idle) |
| sp_i | input | 32 | Current stack pointer register |
| stk_wide_i | input | 1 | 1 = 32-bit stack, 0 = 16-bit stack |
| op_wide_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| dst_i | input | 2 | 0 other, 1 stack pointer, 2 memory based on stack pointer, 3 other |
| busy_o | output | 1 | Pop in progress |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Read address (old top of stack) |
| rd_bytes_o | output | 3 | Read byte count, 2 or 4 |
| rd_ack_i | input | 1 | One-cycle read acknowledge |
| rd_data_i | input | 32 | Read data, valid with acknowledge |
| sp_wr_o | output | 1 | Pointer commit strobe |
| sp_next_o | output | 32 | Committed pointer value |
| ea_base_vld_o | output | 1 | Effective-address base valid |
| ea_base_o | output | 32 | Effective-address base from stepped pointer |

## Verification
The bench builds the unit twice. One instance uses the default single-adder variant. The other selects the split carry variant and is driven with the same stimulus, so the 16-bit wrap at 0xFFFE and the 32-bit wrap at 0xFFFFFFFE reach both adder structures. Both instances keep the default 32-bit pointer and the 2/4-byte steps. With those defaults, the mixed case of a 32-bit operand on a 16-bit stack and a 16-bit pop into the pointer of a 32-bit stack lie within reach, along with back-to-back pops and acknowledge delays from zero to several cycles.

// File: rtl/stkpop_pkg.sv
package stkpop_pkg;

   typedef enum logic [1:0] {
      DST_PLAIN  = 2'd0,
      DST_SELF   = 2'd1,
      DST_MEM_SP = 2'd2,
      DST_RSVD   = 2'd3
   } stkpop_dst_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } stkpop_state_e;

   typedef struct packed {
      logic        stk_wide;
      logic        op_wide;
      stkpop_dst_e dst;
   } stkpop_ctx_t;

endpackage

// File: rtl/stkpop_size_sel.sv
module stkpop_size_sel #(
   parameter int unsigned NARROW_BYTES = 2,
   parameter int unsigned WIDE_BYTES   = 4,
   parameter int unsigned CNT_W        = 3
) (
   input  logic             op_wide,
   output logic [CNT_W-1:0] step
);
   localparam logic [CNT_W-1:0] NARROW_C = CNT_W'(NARROW_BYTES);
   localparam logic [CNT_W-1:0] WIDE_C   = CNT_W'(WIDE_BYTES);

   always_comb begin
      step = op_wide ? WIDE_C : NARROW_C;
   end
endmodule

// File: rtl/stkpop_ptr_adder.sv
module stkpop_ptr_adder #(
   parameter int unsigned PTR_W       = 32,
   parameter int unsigned INC_W       = 3,
   parameter bit          SPLIT_CARRY = 1'b0
) (
   input  logic [PTR_W-1:0] ptr,
   input  logic [INC_W-1:0] inc,
   input  logic             stk_wide,
   output logic [PTR_W-1:0] sum
);
   localparam int unsigned HALF_W = PTR_W / 2;

   generate
      if (SPLIT_CARRY) begin : g_split
         logic [HALF_W:0]   lo_sum;
         logic [HALF_W-1:0] hi_sum;
         always_comb begin
            lo_sum = {1'b0, ptr[HALF_W-1:0]} + (HALF_W+1)'(inc);
            hi_sum = ptr[PTR_W-1:HALF_W] + HALF_W'(lo_sum[HALF_W]);
            sum    = {stk_wide ? hi_sum : ptr[PTR_W-1:HALF_W], lo_sum[HALF_W-1:0]};
         end
      end else begin : g_flat
         logic [PTR_W-1:0] full;
         always_comb begin
            full = ptr + PTR_W'(inc);
            sum  = stk_wide ? full : {ptr[PTR_W-1:HALF_W], full[HALF_W-1:0]};
         end
      end
   endgenerate
endmodule

// File: rtl/stkpop_addr_view.sv
module stkpop_addr_view #(
   parameter int unsigned PTR_W = 32
) (
   input  logic [PTR_W-1:0] ptr,
   input  logic             stk_wide,
   output logic [PTR_W-1:0] addr
);
   localparam int unsigned HALF_W = PTR_W / 2;

   always_comb begin
      addr = stk_wide ? ptr : {{HALF_W{1'b0}}, ptr[HALF_W-1:0]};
   end
endmodule

// File: rtl/stkpop_ctrl.sv
module stkpop_ctrl
   import stkpop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ack,
   output logic busy,
   output logic load,
   output logic commit
);
   stkpop_state_e state_q;

   always_comb begin
      busy   = (state_q == ST_WAIT);
      load   = start && (state_q == ST_IDLE);
      commit = ack && (state_q == ST_WAIT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else if (load) begin
         state_q <= ST_WAIT;
      end else if (commit) begin
         state_q <= ST_IDLE;
      end
   end

   a_r9_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !ack |=> busy);
endmodule

// File: rtl/stkpop_unit.sv
module stkpop_unit
   import stkpop_pkg::*;
#(
   parameter int unsigned PTR_W        = 32,
   parameter int unsigned NARROW_BYTES = 2,
   parameter int unsigned WIDE_BYTES   = 4,
   parameter bit          SPLIT_CARRY  = 1'b0,
   localparam int unsigned CNT_W       = $clog2(WIDE_BYTES + 1),
   localparam int unsigned HALF_W      = PTR_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [PTR_W-1:0] sp_i,
   input  logic             stk_wide_i,
   input  logic             op_wide_i,
   input  logic [1:0]       dst_i,
   output logic             busy_o,
   output logic             rd_req_o,
   output logic [PTR_W-1:0] rd_addr_o,
   output logic [CNT_W-1:0] rd_bytes_o,
   input  logic             rd_ack_i,
   input  logic [PTR_W-1:0] rd_data_i,
   output logic             sp_wr_o,
   output logic [PTR_W-1:0] sp_next_o,
   output logic             ea_base_vld_o,
   output logic [PTR_W-1:0] ea_base_o
);
   generate
      if ((PTR_W % 2) != 0 || PTR_W < 4) begin : g_bad_width
         $error("stkpop_unit: PTR_W must be even and at least 4");
      end
      if (WIDE_BYTES <= NARROW_BYTES || NARROW_BYTES == 0) begin : g_bad_step
         $error("stkpop_unit: need 0 < NARROW_BYTES < WIDE_BYTES");
      end
   endgenerate

   logic             busy, load, commit;
   stkpop_ctx_t      ctx_q;
   logic [PTR_W-1:0] sp_q;
   logic [CNT_W-1:0] step;
   logic [PTR_W-1:0] stepped, stepped_view, final_sp;

   stkpop_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .ack    (rd_ack_i),
      .busy   (busy),
      .load   (load),
      .commit (commit)
   );

   stkpop_size_sel #(
      .NARROW_BYTES (NARROW_BYTES),
      .WIDE_BYTES   (WIDE_BYTES),
      .CNT_W        (CNT_W)
   ) u_size (
      .op_wide (ctx_q.op_wide),
      .step    (step)
   );

   stkpop_ptr_adder #(
      .PTR_W       (PTR_W),
      .INC_W       (CNT_W),
      .SPLIT_CARRY (SPLIT_CARRY)
   ) u_add (
      .ptr      (sp_q),
      .inc      (step),
      .stk_wide (ctx_q.stk_wide),
      .sum      (stepped)
   );

   stkpop_addr_view #(.PTR_W(PTR_W)) u_rd_view (
      .ptr      (sp_q),
      .stk_wide (ctx_q.stk_wide),
      .addr     (rd_addr_o)
   );

   stkpop_addr_view #(.PTR_W(PTR_W)) u_ea_view (
      .ptr      (stepped),
      .stk_wide (ctx_q.stk_wide),
      .addr     (stepped_view)
   );

   always_comb begin
      unique case (ctx_q.dst)
         DST_SELF:
            final_sp = ctx_q.op_wide ? rd_data_i
                                     : {stepped[PTR_W-1:HALF_W], rd_data_i[HALF_W-1:0]};
         default:
            final_sp = stepped;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_q <= '{stk_wide: 1'b0, op_wide: 1'b0, dst: DST_PLAIN};
         sp_q  <= '0;
      end else if (load) begin
         ctx_q <= '{stk_wide: stk_wide_i, op_wide: op_wide_i, dst: stkpop_dst_e'(dst_i)};
         sp_q  <= sp_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_wr_o       <= 1'b0;
         ea_base_vld_o <= 1'b0;
         sp_next_o     <= '0;
         ea_base_o     <= '0;
      end else begin
         sp_wr_o       <= commit;
         ea_base_vld_o <= commit && (ctx_q.dst == DST_MEM_SP);
         if (commit) begin
            sp_next_o <= final_sp;
            ea_base_o <= stepped_view;
         end
      end
   end

   always_comb begin
      busy_o     = busy;
      rd_req_o   = busy;
      rd_bytes_o = step;
   end

   a_r2_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> rd_req_o);
   a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_bytes_o));
   a_r3_bytes_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_bytes_o == CNT_W'(NARROW_BYTES)) || (rd_bytes_o == CNT_W'(WIDE_BYTES)));
   a_r6_commit_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && rd_ack_i |=> sp_wr_o && !rd_req_o);
   a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr_o |=> !sp_wr_o);
   a_r7_vld_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
      ea_base_vld_o |-> sp_wr_o);
   a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr_o && !ctx_q.stk_wide && (ctx_q.dst != DST_SELF)
      |-> sp_next_o[PTR_W-1:HALF_W] == sp_q[PTR_W-1:HALF_W]);
endmodule

// File: tb/stkpop_unit_tb.sv
module stkpop_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] sp_i = '0;
   logic        stk_wide_i = 1'b0;
   logic        op_wide_i = 1'b0;
   logic [1:0]  dst_i = '0;
   logic        rd_ack_i = 1'b0;
   logic [31:0] rd_data_i = '0;

   logic        busy_o, rd_req_o, sp_wr_o, ea_base_vld_o;
   logic [31:0] rd_addr_o, sp_next_o, ea_base_o;
   logic [2:0]  rd_bytes_o;
   logic        busy_b, rd_req_b, sp_wr_b, ea_vld_b;
   logic [31:0] rd_addr_b, sp_next_b, ea_base_b;
   logic [2:0]  rd_bytes_b;

   always #10 clk = ~clk;

   stkpop_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i),
      .stk_wide_i(stk_wide_i), .op_wide_i(op_wide_i), .dst_i(dst_i),
      .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_bytes_o(rd_bytes_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
      .sp_wr_o(sp_wr_o), .sp_next_o(sp_next_o),
      .ea_base_vld_o(ea_base_vld_o), .ea_base_o(ea_base_o));

   stkpop_unit #(.SPLIT_CARRY(1'b1)) u_dut_split (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i),
      .stk_wide_i(stk_wide_i), .op_wide_i(op_wide_i), .dst_i(dst_i),
      .busy_o(busy_b), .rd_req_o(rd_req_b), .rd_addr_o(rd_addr_b),
      .rd_bytes_o(rd_bytes_b), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
      .sp_wr_o(sp_wr_b), .sp_next_o(sp_next_b),
      .ea_base_vld_o(ea_vld_b), .ea_base_o(ea_base_b));

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 0;

   // behavioural reference state
   bit          m_busy = 0, m_wr = 0, m_vld = 0;
   bit          m_s32 = 0, m_o32 = 0;
   int          m_dst = 0;
   logic [31:0] m_sp = '0, m_next = '0, m_ea = '0;
   string       m_tag = "R1";

   function automatic logic [31:0] view(logic [31:0] p, bit s32);
      return s32 ? p : (p & 32'h0000_FFFF);
   endfunction

   function automatic logic [31:0] step_ptr(logic [31:0] p, bit s32, bit o32);
      longint unsigned inc = o32 ? 4 : 2;
      if (s32) return 32'((longint'(p) + inc) % 64'h1_0000_0000);
      return (p & 32'hFFFF_0000) | 32'((longint'(p & 32'hFFFF) + inc) % 65536);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 0; m_wr <= 0; m_vld <= 0; m_s32 <= 0; m_o32 <= 0;
         m_dst <= 0; m_sp <= '0; m_next <= '0; m_ea <= '0; m_tag <= "R1";
      end else begin
         logic [31:0] st;
         st = step_ptr(m_sp, m_s32, m_o32);
         m_wr <= 0; m_vld <= 0;
         if (m_busy && rd_ack_i) begin
            m_busy <= 0;
            m_wr   <= 1;
            m_vld  <= (m_dst == 2);
            m_ea   <= view(st, m_s32);
            if (m_dst == 1) begin
               m_next <= m_o32 ? rd_data_i : ((st & 32'hFFFF_0000) | (rd_data_i & 32'hFFFF));
               m_tag  <= "R8";
            end else begin
               m_next <= st;
               m_tag  <= m_s32 ? "R4" : "R5";
            end
         end else if (!m_busy && start_i) begin
            m_busy <= 1; m_sp <= sp_i; m_s32 <= stk_wide_i;
            m_o32 <= op_wide_i; m_dst <= int'(dst_i);
         end
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   // per-cycle comparison against the reference, both adder variants
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         chk("R2", "busy", 32'(busy_o), 32'(m_busy));
         chk("R10", "rd_req", 32'(rd_req_o), 32'(m_busy));
         chk("R2", "rd_addr", rd_addr_o, view(m_sp, m_s32));
         chk("R3", "rd_bytes", 32'(rd_bytes_o), m_o32 ? 32'd4 : 32'd2);
         chk("R6", "sp_wr", 32'(sp_wr_o), 32'(m_wr));
         chk(m_tag, "sp_next", sp_next_o, m_next);
         chk("R7", "ea_vld", 32'(ea_base_vld_o), 32'(m_vld));
         chk("R7", "ea_base", ea_base_o, m_ea);
         chk("R6", "split sp_wr", 32'(sp_wr_b), 32'(m_wr));
         chk(m_tag, "split sp_next", sp_next_b, m_next);
         chk("R7", "split ea_base", ea_base_b, m_ea);
         chk("R2", "split rd_addr", rd_addr_b, view(m_sp, m_s32));
         chk("R3", "split rd_bytes", 32'(rd_bytes_b), m_o32 ? 32'd4 : 32'd2);
         chk("R2", "split busy", 32'(busy_b | rd_req_b | ea_vld_b) & 32'(busy_b),
             32'(m_busy));
      end
   end

   task automatic pop(logic [31:0] sp, bit s32, bit o32, logic [1:0] dst,
                      logic [31:0] data, int delay, bit junk_start);
      @(negedge clk); #1;
      start_i = 1; sp_i = sp; stk_wide_i = s32; op_wide_i = o32; dst_i = dst;
      @(negedge clk); #1;
      start_i = 0;
      for (int i = 0; i < delay; i++) begin
         if (junk_start && i == 0) begin
            // R9: start while busy with different context
            start_i = 1; sp_i = ~sp; stk_wide_i = ~s32; op_wide_i = ~o32; dst_i = ~dst;
         end else begin
            start_i = 0;
         end
         @(negedge clk); #1;
      end
      start_i = 0;
      rd_ack_i = 1; rd_data_i = data;
      @(negedge clk); #1;
      rd_ack_i = 0; rd_data_i = 32'hDEAD_BEEF;
   endtask

   initial begin
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "busy in reset", 32'(busy_o), 0);
      chk("R1", "rd_req in reset", 32'(rd_req_o), 0);
      chk("R1", "sp_wr in reset", 32'(sp_wr_o), 0);
      chk("R1", "rd_bytes in reset", 32'(rd_bytes_o), 2);
      chk("R1", "sp_next in reset", sp_next_o, 0);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R1", "rd_addr after reset", rd_addr_o, 0);
      chk("R1", "ea_vld after reset", 32'(ea_base_vld_o), 0);

      pop(32'h0001_0100, 1, 1, 2'd0, 32'h1111_2222, 0, 0);     // R4 basic
      pop(32'hABCD_FFFE, 0, 0, 2'd0, 32'h0, 1, 0);             // R5 wrap 16/16
      pop(32'hABCD_FFFE, 0, 1, 2'd2, 32'h0, 2, 0);             // R5 op32 on 16-bit stack, R7
      pop(32'hFFFF_FFFE, 1, 1, 2'd2, 32'h0, 0, 0);             // R4 32-bit wrap, R7
      pop(32'h0000_FFFE, 1, 0, 2'd3, 32'h0, 0, 0);             // R4 carry into upper
      pop(32'h1234_5678, 1, 1, 2'd1, 32'hCAFE_F00D, 3, 0);     // R8 op32
      pop(32'h1234_FFFE, 1, 0, 2'd1, 32'h5555_9999, 1, 0);     // R8 op16 on 32-bit stack
      pop(32'h7777_0010, 0, 0, 2'd1, 32'hAAAA_4321, 0, 0);     // R8 on 16-bit stack
      pop(32'h0000_2000, 1, 0, 2'd2, 32'h0, 4, 1);             // R9 junk start
      // R9: committed result of the pop above reflects its own context only
      @(negedge clk);
      chk("R9", "ea_base after ignored start", ea_base_o, 32'h0000_2002);
      // R6/R10: ack while idle has no effect
      #1 rd_ack_i = 1;
      @(negedge clk); #1 rd_ack_i = 0;
      @(negedge clk);
      chk("R6", "no strobe from idle ack", 32'(sp_wr_o), 0);

      for (int k = 0; k < 300; k++) begin
         pop($urandom, 1'($urandom), 1'($urandom), 2'($urandom), $urandom,
             int'($urandom % 4), 1'($urandom));
      end
      repeat (4) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule